// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block loads a configuration image into an FPGA that sits in slave-serial mode. After a start pulse it drives the target's active-low program pin low to clear the target. It then waits for the target's init pin to fall, releases the program pin and waits for init to rise again. Next it shifts the image out one bit per configuration clock and waits for the done pin to rise.

Image bytes arrive on a byte-wide ready/valid stream. The number of bytes is given with the start pulse. Every waiting phase has its own timeout, counted in clock cycles and set by a parameter. The final result is a two-bit status that is presented together with a one-cycle valid pulse. Status code 0 means success, code 1 means init never went low, code 2 means init never went high again, and code 3 means done never rose.

Top module: `fpga_serial_loader`

## Requirements
- R1: Out of reset, `prog_n_o` is high, `cclk_o` is low, and `busy_o`, `status_valid_o` and `s_ready_o` are all low.
- R2: A start accepted while idle drives `prog_n_o` low and `busy_o` high on the following cycle.
- R3: If `init_i` stays high for T_INIT_LOW cycles while the program pin is low, `busy_o` falls and `status_valid_o` pulses T_INIT_LOW cycles after the start edge, with status code 1. No image byte is accepted in this case.
- R4: Once `init_i` is seen low, `prog_n_o` returns high. If `init_i` then stays low for T_INIT_HIGH cycles, the run ends with status code 2 and no image byte is accepted.
- R5: Each byte goes out most-significant bit first on `cdata_o`, with exactly one rising `cclk_o` edge per bit. `cdata_o` is stable for at least one clock before each rising edge. A run of N bytes gives exactly 8*N rising edges.
- R6: `s_ready_o` is high only after init has gone high again, only while the shifter is empty, and only while some of the byte count remains. Bytes offered beyond the count are never taken.
- R7: If `done_i` stays low for T_DONE cycles after the last bit, the run ends with status code 3.
- R8: If `done_i` rises after the last bit, the run ends with status code 0. `status_valid_o` is a one-cycle pulse in the cycle `busy_o` first reads low, and `status_o` holds its value afterwards.
- R9: A start pulse while `busy_o` is high is ignored: the run's timing and result are unchanged and no second run follows.
- R10: A byte count of zero goes straight to the done wait, with no `cclk_o` edges and no bytes accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a configuration run (sampled while idle) |
| byte_count_i | input | CNT_W | Number of image bytes, sampled with start |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_ready_o | output | 1 | Image byte accepted when high with valid |
| prog_n_o | output | 1 | Active-low program pin to target |
| cclk_o | output | 1 | Configuration clock to target |
| cdata_o | output | 1 | Serial configuration data to target |
| init_i | input | 1 | Target init pin level |
| done_i | input | 1 | Target done pin level |
| busy_o | output | 1 | Run in progress |
| status_valid_o | output | 1 | One-cycle pulse when the result is presented |
| status_o | output | 2 | Result: 0 ok, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench sweeps byte counts from zero to five against several stream stall patterns. It rebuilds every byte from the rising configuration-clock edges. A shifter that sent the least-significant bit first, or gave one edge too few or too many, would corrupt the recovered bytes or the edge total. The bench also offers bytes beyond the count, so a loader that ignored the count would be seen taking extra bytes. The two init timeouts are timed to the exact cycle; an off-by-one phase counter, or a timer that a stray start pulse restarts, would show up as a wrong latency. Swapped status codes, or data taken before init went high again, show up as a wrong code or a non-zero accept count.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

   // Result codes presented on status_o
   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_INIT_LO = 2'd1,
      RES_INIT_HI = 2'd2,
      RES_DONE    = 2'd3
   } fsl_result_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CLEAR = 3'd1,
      PH_REL   = 3'd2,
      PH_SHIFT = 3'd3,
      PH_WDONE = 3'd4
   } fsl_phase_e;

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/fsl_phase_timer.sv
module fsl_phase_timer #(
   parameter int TW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          run_i,
   input  logic [TW-1:0] limit_i,
   output logic          expired_o
);

   logic [TW-1:0] cnt_q;

   assign expired_o = run_i && (cnt_q == limit_i - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr_i)                 cnt_q <= '0;
      else if (run_i && !expired_o)   cnt_q <= cnt_q + TW'(1);
   end

   // R3
   timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
   parameter int CNT_W    = 16,
   parameter int HALF_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             en_i,
   input  logic [7:0]       s_data_i,
   input  logic             s_valid_i,
   output logic             s_ready_o,
   output logic             cclk_o,
   output logic             cdata_o,
   output logic             empty_o
);

   localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   logic [CNT_W-1:0] remain_q;
   logic [7:0]       sh_q;
   logic [2:0]       bit_q;
   logic             full_q;
   logic             hi_q;
   logic             fire;
   logic             tick;

   assign s_ready_o = en_i && !full_q && (remain_q != '0);
   assign fire      = s_valid_i && s_ready_o;
   assign empty_o   = !full_q && (remain_q == '0);
   assign cclk_o    = hi_q;
   assign cdata_o   = sh_q[7];

   generate
      if (HALF_CYC == 1) begin : g_nodiv
         assign tick = full_q;
      end else begin : g_div
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                div_q <= '0;
            else if (!full_q || fire)                  div_q <= '0;
            else if (div_q == DW'(HALF_CYC - 1))       div_q <= '0;
            else                                       div_q <= div_q + DW'(1);
         end
         assign tick = full_q && (div_q == DW'(HALF_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         sh_q     <= '0;
         bit_q    <= '0;
         full_q   <= 1'b0;
         hi_q     <= 1'b0;
      end else if (load_i) begin
         remain_q <= count_i;
         full_q   <= 1'b0;
         hi_q     <= 1'b0;
      end else if (fire) begin
         sh_q     <= s_data_i;
         bit_q    <= '0;
         full_q   <= 1'b1;
         hi_q     <= 1'b0;
         remain_q <= remain_q - CNT_W'(1);
      end else if (tick) begin
         if (!hi_q) begin
            hi_q <= 1'b1;
         end else begin
            hi_q <= 1'b0;
            if (bit_q == 3'd7) begin
               full_q <= 1'b0;
            end else begin
               sh_q  <= {sh_q[6:0], 1'b0};
               bit_q <= bit_q + 3'd1;
            end
         end
      end
   end

   // R5
   data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk_o) |-> $stable(cdata_o));

   // R6
   no_take_while_clocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cclk_o |-> !s_ready_o);

endmodule

// File: rtl/fsl_ctrl.sv
module fsl_ctrl
   import fsl_pkg::*;
#(
   parameter int TW          = 20,
   parameter int T_INIT_LOW  = 500_000,
   parameter int T_INIT_HIGH = 500_000,
   parameter int T_DONE      = 1_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          init_i,
   input  logic          done_i,
   input  logic          shift_empty_i,
   input  logic          expired_i,
   output logic          load_o,
   output logic          shift_en_o,
   output logic          tmr_clr_o,
   output logic          tmr_run_o,
   output logic [TW-1:0] limit_o,
   output logic          prog_n_o,
   output logic          busy_o,
   output logic          status_valid_o,
   output logic [1:0]    status_o
);

   fsl_phase_e  ph_q, ph_d;
   logic        fin;
   fsl_result_e res;
   logic        svld_q;
   fsl_result_e res_q;

   always_comb begin
      ph_d = ph_q;
      fin  = 1'b0;
      res  = RES_OK;
      unique case (ph_q)
         PH_IDLE:  if (start_i) ph_d = PH_CLEAR;
         PH_CLEAR: if (!init_i) ph_d = PH_REL;
                   else if (expired_i) begin ph_d = PH_IDLE; fin = 1'b1; res = RES_INIT_LO; end
         PH_REL:   if (init_i) ph_d = PH_SHIFT;
                   else if (expired_i) begin ph_d = PH_IDLE; fin = 1'b1; res = RES_INIT_HI; end
         PH_SHIFT: if (shift_empty_i) ph_d = PH_WDONE;
         PH_WDONE: if (done_i) begin ph_d = PH_IDLE; fin = 1'b1; res = RES_OK; end
                   else if (expired_i) begin ph_d = PH_IDLE; fin = 1'b1; res = RES_DONE; end
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_comb begin
      unique case (ph_q)
         PH_CLEAR: limit_o = TW'(T_INIT_LOW);
         PH_REL:   limit_o = TW'(T_INIT_HIGH);
         default:  limit_o = TW'(T_DONE);
      endcase
   end

   assign load_o         = (ph_q == PH_IDLE) && start_i;
   assign shift_en_o     = (ph_q == PH_SHIFT);
   assign tmr_run_o      = (ph_q == PH_CLEAR) || (ph_q == PH_REL) || (ph_q == PH_WDONE);
   assign tmr_clr_o      = (ph_q == PH_IDLE) || (ph_d != ph_q);
   assign prog_n_o       = (ph_q != PH_CLEAR);
   assign busy_o         = (ph_q != PH_IDLE);
   assign status_valid_o = svld_q;
   assign status_o       = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         svld_q <= 1'b0;
         res_q  <= RES_OK;
      end else begin
         ph_q   <= ph_d;
         svld_q <= fin;
         if (fin) res_q <= res;
      end
   end

   // R8
   status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid_o |=> !status_valid_o);

   // R8
   status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid_o |-> !busy_o);

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> !prog_n_o);

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && prog_n_o) |=> prog_n_o);

endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
   import fsl_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int HALF_CYC    = 2,
   parameter int T_INIT_LOW  = 500_000,
   parameter int T_INIT_HIGH = 500_000,
   parameter int T_DONE      = 1_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] byte_count_i,
   input  logic [7:0]       s_data_i,
   input  logic             s_valid_i,
   output logic             s_ready_o,
   output logic             prog_n_o,
   output logic             cclk_o,
   output logic             cdata_o,
   input  logic             init_i,
   input  logic             done_i,
   output logic             busy_o,
   output logic             status_valid_o,
   output logic [1:0]       status_o
);

   localparam int T_MAX = max3(T_INIT_LOW, T_INIT_HIGH, T_DONE);
   localparam int TW    = $clog2(T_MAX + 1);

   generate
      if (T_INIT_LOW < 1 || T_INIT_HIGH < 1 || T_DONE < 1) begin : g_bad_tmo
         $error("timeouts must be at least one cycle");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least one");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least one");
      end
   endgenerate

   logic          load;
   logic          shift_en;
   logic          shift_empty;
   logic          tmr_clr;
   logic          tmr_run;
   logic          expired;
   logic [TW-1:0] limit;

   fsl_ctrl #(
      .TW          (TW),
      .T_INIT_LOW  (T_INIT_LOW),
      .T_INIT_HIGH (T_INIT_HIGH),
      .T_DONE      (T_DONE)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .init_i         (init_i),
      .done_i         (done_i),
      .shift_empty_i  (shift_empty),
      .expired_i      (expired),
      .load_o         (load),
      .shift_en_o     (shift_en),
      .tmr_clr_o      (tmr_clr),
      .tmr_run_o      (tmr_run),
      .limit_o        (limit),
      .prog_n_o       (prog_n_o),
      .busy_o         (busy_o),
      .status_valid_o (status_valid_o),
      .status_o       (status_o)
   );

   fsl_phase_timer #(.TW(TW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (tmr_clr),
      .run_i     (tmr_run),
      .limit_i   (limit),
      .expired_o (expired)
   );

   fsl_shifter #(.CNT_W(CNT_W), .HALF_CYC(HALF_CYC)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .count_i   (byte_count_i),
      .en_i      (shift_en),
      .s_data_i  (s_data_i),
      .s_valid_i (s_valid_i),
      .s_ready_o (s_ready_o),
      .cclk_o    (cclk_o),
      .cdata_o   (cdata_o),
      .empty_o   (shift_empty)
   );

   // R5
   cclk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cclk_o |-> busy_o);

   // R6
   ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> (prog_n_o && busy_o));

endmodule

// File: tb/fpga_serial_loader_bench.sv
module fpga_serial_loader_bench;

   localparam int CW   = 8;
   localparam int HALF = 2;
   localparam int TIL  = 40;
   localparam int TIH  = 30;
   localparam int TDN  = 50;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] count = '0;
   logic [7:0]    s_data = '0;
   logic          s_valid = 1'b0;
   logic          s_ready, prog_n, cclk, cdata, busy, svld;
   logic          init_pin = 1'b1;
   logic          done_pin = 1'b0;
   logic [1:0]    status;

   int nchk = 0;
   int nfail = 0;

   // target model controls
   bit rl, rh, dk;
   int n_cur = 0;
   int gap = 1;
   int seed = 0;
   bit src_on = 1'b0;
   int idx = 0;
   bit fire_p = 1'b0;
   int cyc = 0;
   int rises = 0;
   logic [7:0] rxb [0:7];

   always #5 clk = ~clk;

   fpga_serial_loader #(
      .CNT_W(CW), .HALF_CYC(HALF), .T_INIT_LOW(TIL), .T_INIT_HIGH(TIH), .T_DONE(TDN)
   ) u_fpga_serial_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(count),
      .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
      .prog_n_o(prog_n), .cclk_o(cclk), .cdata_o(cdata),
      .init_i(init_pin), .done_i(done_pin),
      .busy_o(busy), .status_valid_o(svld), .status_o(status)
   );

   function automatic logic [7:0] pat(int i, int s);
      return 8'((i * 37 + s * 11) ^ 8'hA5);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // stream source, driven at the falling edge
   always @(negedge clk) begin
      if (fire_p) idx = idx + 1;
      s_valid = src_on && (idx < n_cur + 2) && ((cyc % gap) == 0);
      s_data  = pat(idx, seed);
      fire_p  = s_valid && s_ready;
   end

   // target pin model
   always @(negedge clk) begin
      if (!prog_n && rl) init_pin <= 1'b0;
      else if (prog_n && rh && !init_pin) init_pin <= 1'b1;
      if (dk && busy && prog_n && init_pin && rises == 8 * n_cur && idx == n_cur)
         done_pin <= 1'b1;
   end

   // receive side of the target
   always @(posedge cclk) begin
      rxb[(rises / 8) % 8] = {rxb[(rises / 8) % 8][6:0], cdata};
      rises = rises + 1;
   end

   task automatic run(int n, bit l, bit h, bit d, int g, int s, int ecode, int elat, bit poke);
      int lat;
      rl = l; rh = h; dk = d; gap = g; seed = s;
      @(negedge clk);
      init_pin = 1'b1; done_pin = 1'b0; rises = 0; idx = 0; n_cur = n; src_on = 1'b1;
      start = 1'b1; count = CW'(n);
      @(negedge clk);
      start = 1'b0;
      // R2: program low and busy high one cycle after start
      chk(!prog_n && busy, "R2 prog low/busy after start", {prog_n, busy}, 1);
      lat = 0;
      while (!svld && lat < 3000) begin
         @(negedge clk);
         lat++;
         start = poke && (lat == 5);
      end
      start = 1'b0;
      chk(svld, "watchdog run end", svld, 1);
      if (ecode == 1) chk(status == 2'd1, "R3 init-low timeout code", status, 1);
      if (ecode == 2) chk(status == 2'd2, "R4 init-high timeout code", status, 2);
      if (ecode == 3) chk(status == 2'd3, "R7 done timeout code", status, 3);
      if (ecode == 0) chk(status == 2'd0, "R8 success code", status, 0);
      if (elat >= 0) begin
         if (poke) chk(lat == elat, "R9 busy start ignored latency", lat, elat);
         else if (ecode == 1) chk(lat == elat, "R3 timeout latency", lat, elat);
         else chk(lat == elat, "R4 timeout latency", lat, elat);
      end
      if (ecode <= 1 || ecode == 2) begin
         if (ecode != 0) chk(idx == 0 && rises == 0, "R6 no data before init high", idx * 100 + rises, 0);
      end
      if (ecode == 0 || ecode == 3) begin
         if (n == 0) chk(rises == 0 && idx == 0, "R10 zero count no clocks", rises, 0);
         else chk(rises == 8 * n, "R5 clock edge count", rises, 8 * n);
         chk(idx == n, "R6 bytes accepted equals count", idx, n);
         for (int i = 0; i < n; i++)
            chk(rxb[i] == pat(i, s), "R5 msb-first byte", rxb[i], pat(i, s));
      end
      src_on = 1'b0;
      @(negedge clk);
      chk(!busy && !svld && status == 2'(ecode), "R8 pulse ends, status held", {busy, svld, status}, ecode);
      repeat (4) @(negedge clk);
      chk(!busy && prog_n, "R9 no second run", {busy, prog_n}, 1);
   endtask

   initial begin
      #2_000_000;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(prog_n && !cclk && !busy && !svld && !s_ready, "R1 reset state",
          {prog_n, cclk, busy, svld, s_ready}, 5'b10000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && prog_n && !s_ready, "R1 idle after reset", {busy, prog_n, s_ready}, 3'b010);

      run(0, 1'b0, 1'b0, 1'b0, 1, 0, 1, TIL, 1'b0);       // R3
      run(0, 1'b0, 1'b0, 1'b0, 1, 0, 1, TIL, 1'b1);       // R9 start during run
      run(3, 1'b1, 1'b0, 1'b0, 1, 0, 2, TIH + 1, 1'b0);   // R4
      run(2, 1'b1, 1'b1, 1'b0, 1, 3, 3, -1, 1'b0);        // R7
      run(0, 1'b1, 1'b1, 1'b1, 1, 0, 0, -1, 1'b0);        // R10
      for (int n = 1; n <= 5; n++)
         for (int g = 1; g <= 3; g++)
            run(n, 1'b1, 1'b1, 1'b1, g, n * 3 + g, 0, -1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule